// File: doc/BRIEF.md
# Toggle-on-Write Interrupt Register Bank

This block holds the interrupt state of a peripheral. It has a status register and an enable register, each 32 bits wide, and a single registered interrupt line. Event inputs from the peripheral set status bits, and those bits stay set until software acts on them. The enable register selects which status bits can drive the interrupt line. Software reaches both registers through a register port with a single-cycle write strobe and a combinational read.

The number of implemented interrupt bits is a parameter. The implemented bits fill the register from bit 31 downward, and every lower bit is fixed at zero. Writing a one to a status bit inverts that bit. Software can therefore raise an interrupt by writing one to a clear bit, and it acknowledges an interrupt by writing one to a set bit. A per-bit reset-value parameter lets chosen status bits leave reset already set. A per-bit sticky parameter marks error bits that software cannot acknowledge. Once set, a sticky bit holds its interrupt until the next reset.

Top module: `irq_bank`

## Requirements
- R1: A reset clears the enable register and the interrupt line, and it loads each implemented status bit with its bit of STATUS_INIT.
- R2: With NUM_BITS = N, the implemented bits are bits 31 down to 32-N. All lower bits read as zero and are unaffected by writes and by event inputs.
- R3: An event input bit that is high in one cycle sets the matching implemented status bit at the next clock edge. The bit stays set after the event input falls.
- R4: A write to offset 0x0 inverts every implemented, non-sticky status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R5: A write to offset 0x4 stores the implemented data bits in the enable register. Reading offset 0x4 returns exactly that value, so writing 0 disables every interrupt.
- R6: A status bit flagged in STICKY can be set by an event or by a write of one, but a write of one does not clear it. Only a reset clears it.
- R7: When an event and a toggle write hit the same status bit in the same cycle, the bit is set after the edge.
- R8: The interrupt line is a register. One cycle after the status and enable registers share a set bit, it is 1. One cycle after they share none, it is 0.
- R9: Reads of offset 0x0 return the status register and reads of offset 0x4 return the enable register. A read of any other offset returns zero, and a write to any other offset changes no register.
- R10: With NUM_BITS = 0, every read returns zero and the interrupt line stays 0, whatever is written or signalled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | ADDR_W | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| evt_in | input | 32 | Event inputs, aligned to status bit positions |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
A hardware event and a software toggle write can reach the same status bit in the same clock cycle. The bench provokes this case by driving one event bit and a status write with a one in that same position during a single low clock phase. The bit chosen is already set, so a toggle taken alone would clear it. The bench then reads the status register back and expects the bit to be set. It also expects a neighbouring bit that was clear to be set by either source.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int unsigned REG_W      = 32;
    localparam int unsigned STATUS_OFS = 0;
    localparam int unsigned ENABLE_OFS = 4;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_ENABLE
    } reg_sel_e;

    typedef struct packed {
        logic             wr_status;
        logic             wr_enable;
        logic [REG_W-1:0] data;
    } wr_req_t;

    // Bits n..1 counted from the MSB are implemented.
    function automatic logic [REG_W-1:0] impl_mask(int unsigned n);
        logic [REG_W-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < REG_W; i++) begin
            if (i + n >= REG_W) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode
    import irq_bank_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output reg_sel_e          sel,
    output wr_req_t           req
);

    always_comb begin
        if (addr == ADDR_W'(STATUS_OFS))      sel = SEL_STATUS;
        else if (addr == ADDR_W'(ENABLE_OFS)) sel = SEL_ENABLE;
        else                                  sel = SEL_NONE;
    end

    always_comb begin
        req.wr_status = wr_en && (sel == SEL_STATUS);
        req.wr_enable = wr_en && (sel == SEL_ENABLE);
        req.data      = wdata;
    end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_bank_pkg::*;
#(
    parameter int unsigned      NUM_BITS    = 8,
    parameter logic [REG_W-1:0] STATUS_INIT = '0,
    parameter logic [REG_W-1:0] STICKY      = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_req_t          req,
    input  logic [REG_W-1:0] evt_in,
    output logic [REG_W-1:0] status_q
);

    localparam logic [REG_W-1:0] IMPL = impl_mask(NUM_BITS);

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (IMPL[i]) begin : g_impl
            logic bit_q;
            logic toggle;

            assign toggle = req.wr_status && req.data[i];

            always_ff @(posedge clk) begin
                if (rst) begin
                    bit_q <= STATUS_INIT[i];
                end else if (evt_in[i]) begin
                    bit_q <= 1'b1;
                end else if (toggle) begin
                    if (!(STICKY[i] && bit_q)) bit_q <= ~bit_q;
                end
            end

            assign status_q[i] = bit_q;
        end else begin : g_none
            assign status_q[i] = 1'b0;
        end
    end

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
    import irq_bank_pkg::*;
#(
    parameter int unsigned NUM_BITS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_req_t          req,
    output logic [REG_W-1:0] enable_q
);

    localparam logic [REG_W-1:0] IMPL = impl_mask(NUM_BITS);

    always_ff @(posedge clk) begin
        if (rst)                enable_q <= '0;
        else if (req.wr_enable) enable_q <= req.data & IMPL;
    end

endmodule

// File: rtl/irq_line_reg.sv
module irq_line_reg
    import irq_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] status_q,
    input  logic [REG_W-1:0] enable_q,
    output logic             irq
);

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(status_q & enable_q);
    end

endmodule

// File: rtl/irq_bank.sv
module irq_bank
    import irq_bank_pkg::*;
#(
    parameter int unsigned      NUM_BITS    = 8,
    parameter int unsigned      ADDR_W      = 8,
    parameter logic [REG_W-1:0] STATUS_INIT = '0,
    parameter logic [REG_W-1:0] STICKY      = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic [REG_W-1:0]  evt_in,
    output logic              irq
);

    reg_sel_e         sel;
    wr_req_t          req;
    logic [REG_W-1:0] status_q;
    logic [REG_W-1:0] enable_q;

    irq_bank_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .sel   (sel),
        .req   (req)
    );

    irq_status_bank #(
        .NUM_BITS    (NUM_BITS),
        .STATUS_INIT (STATUS_INIT),
        .STICKY      (STICKY)
    ) u_status (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .evt_in   (evt_in),
        .status_q (status_q)
    );

    irq_enable_reg #(.NUM_BITS(NUM_BITS)) u_enable (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .enable_q (enable_q)
    );

    irq_line_reg u_line (
        .clk      (clk),
        .rst      (rst),
        .status_q (status_q),
        .enable_q (enable_q),
        .irq      (irq)
    );

    always_comb begin
        unique case (sel)
            SEL_STATUS: rdata = status_q;
            SEL_ENABLE: rdata = enable_q;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk
    import irq_bank_pkg::*;
#(
    parameter int unsigned      NUM_BITS = 8,
    parameter int unsigned      ADDR_W   = 8,
    parameter logic [REG_W-1:0] STICKY   = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [REG_W-1:0]  wdata,
    input logic [REG_W-1:0]  rdata,
    input logic [REG_W-1:0]  evt_in,
    input logic              irq,
    input logic [REG_W-1:0]  status_q,
    input logic [REG_W-1:0]  enable_q
);

    localparam logic [REG_W-1:0] IMPL  = impl_mask(NUM_BITS);
    localparam logic [REG_W-1:0] STK_M = STICKY & IMPL;

    logic wr_stat;
    logic wr_ena;
    assign wr_stat = wr_en && (addr == ADDR_W'(STATUS_OFS));
    assign wr_ena  = wr_en && (addr == ADDR_W'(ENABLE_OFS));

    // R1
    enable_reset_chk: assert property (@(posedge clk)
        rst |=> (enable_q == '0 && irq == 1'b0));

    // R2
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rdata & ~IMPL) == '0);

    // R3
    status_latch_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_stat |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R5
    enable_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ena |=> (enable_q == ($past(wdata) & IMPL)));

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & $past(status_q) & STK_M) == ($past(status_q) & STK_M)));

    // R7
    event_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|(evt_in & IMPL)) |=> ((status_q & $past(evt_in & IMPL)) == $past(evt_in & IMPL)));

    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (|(status_q & enable_q)) |=> irq);

    // R8
    irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !(|(status_q & enable_q)) |=> !irq);

endmodule

bind irq_bank irq_bank_chk #(
    .NUM_BITS (NUM_BITS),
    .ADDR_W   (ADDR_W),
    .STICKY   (STICKY)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .evt_in   (evt_in),
    .irq      (irq),
    .status_q (status_q),
    .enable_q (enable_q)
);

// File: tb/irq_bank_tb.sv
module irq_bank_tb;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned ADDR_W     = 8;
    localparam logic [31:0] INIT_V     = 32'h4000_0000;
    localparam logic [31:0] STICKY_V   = 32'h0100_0000;

    typedef struct packed {
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp;
    } vec_t;

    // write addr/wdata, then read back addr and expect exp
    localparam vec_t VECS [8] = '{
        '{8'h00, 32'hFFFF_FFFF, 32'hBF00_0000},  // R4 toggle all, R2 low bits ignored
        '{8'h00, 32'h00FF_FFFF, 32'hBF00_0000},  // R2 unimplemented write
        '{8'h00, 32'h8100_0000, 32'h3F00_0000},  // R4 ack bit31, R6 sticky bit24 holds
        '{8'h00, 32'h0000_0000, 32'h3F00_0000},  // R4 zero write
        '{8'h04, 32'hFFFF_FFFF, 32'hFF00_0000},  // R5 enable readback
        '{8'h04, 32'h1234_5678, 32'h1200_0000},  // R5 partial
        '{8'h08, 32'hFFFF_FFFF, 32'h0000_0000},  // R9 other offset
        '{8'h04, 32'h0000_0000, 32'h0000_0000}   // R5 disable all
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       evt_in = '0;
    logic [31:0]       rdata;
    logic              irq;
    logic [31:0]       rdata_e;
    logic              irq_e;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_bank #(
        .NUM_BITS    (8),
        .ADDR_W      (ADDR_W),
        .STATUS_INIT (INIT_V),
        .STICKY      (STICKY_V)
    ) u_dut (
        .clk (clk), .rst (rst), .wr_en (wr_en), .addr (addr),
        .wdata (wdata), .rdata (rdata), .evt_in (evt_in), .irq (irq)
    );

    irq_bank #(
        .NUM_BITS    (0),
        .ADDR_W      (ADDR_W),
        .STATUS_INIT (32'hFFFF_FFFF),
        .STICKY      (32'h0)
    ) u_empty (
        .clk (clk), .rst (rst), .wr_en (wr_en), .addr (addr),
        .wdata (wdata), .rdata (rdata_e), .evt_in (evt_in), .irq (irq_e)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        reg_read(8'h00, v); check("R1 status init", v, INIT_V);
        reg_read(8'h04, v); check("R1 enable zero", v, 32'h0);
        check("R1 irq low", {31'h0, irq}, 32'h0);

        // table walk
        for (int i = 0; i < 8; i++) begin
            reg_write(VECS[i].addr, VECS[i].wdata);
            reg_read(VECS[i].addr, v);
            check($sformatf("R4/R5/R9 vector %0d", i), v, VECS[i].exp);
            check($sformatf("R10 empty read vector %0d", i), rdata_e, 32'h0);
            check("R10 empty irq", {31'h0, irq_e}, 32'h0);
        end
        reg_read(8'h00, v); check("R9 status untouched by other offset", v, 32'h3F00_0000);

        // R8 registered interrupt line
        reg_write(8'h04, 32'h2000_0000);
        check("R8 irq one cycle late", {31'h0, irq}, 32'h0);
        @(negedge clk);
        check("R8 irq raised", {31'h0, irq}, 32'h1);
        reg_write(8'h00, 32'h2000_0000);
        check("R8 irq still high for one cycle", {31'h0, irq}, 32'h1);
        @(negedge clk);
        check("R8 irq dropped after ack", {31'h0, irq}, 32'h0);

        // R6 sticky keeps asserting
        reg_write(8'h04, 32'h0100_0000);
        reg_write(8'h00, 32'h0100_0000);
        @(negedge clk);
        reg_read(8'h00, v); check("R6 sticky not acked", v, 32'h1F00_0000);
        check("R6 sticky irq held", {31'h0, irq}, 32'h1);

        // R3 latching of events
        reg_write(8'h00, 32'h1E00_0000);
        reg_read(8'h00, v); check("R4 ack group", v, 32'h0100_0000);
        @(negedge clk);
        evt_in = 32'h0800_0008;
        @(negedge clk);
        evt_in = 32'h0;
        @(negedge clk);
        reg_read(8'h00, v); check("R3 event latched, R2 low event ignored", v, 32'h0900_0000);

        // R7 event beats toggle on the same bit
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h00; wdata = 32'h0C00_0000; evt_in = 32'h0C00_0000;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0; evt_in = '0;
        reg_read(8'h00, v); check("R7 event wins", v, 32'h0D00_0000);

        // R1/R6 reset clears sticky and restores init
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        reg_read(8'h00, v); check("R6 reset clears sticky", v, INIT_V);
        reg_read(8'h04, v); check("R1 enable cleared", v, 32'h0);
        check("R1 irq cleared", {31'h0, irq}, 32'h0);

        // R10 empty instance after events
        evt_in = 32'hFFFF_FFFF;
        @(negedge clk); evt_in = '0;
        reg_read(8'h00, v); check("R10 empty status", rdata_e, 32'h0);
        reg_read(8'h04, v); check("R10 empty enable", rdata_e, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule